// File: doc/BRIEF.md
# One-Time-Programmable Row Word Programmer

This block writes a single 64-bit word into one row of a one-time-programmable bit array. Only bits that must become 1 are touched. After a start strobe, it walks the bit positions in ascending order. Each bit that needs setting gets one programming pulse of a programmable length on the array's bit-level port. The block then reads the row back once and compares the result with the word it was asked to write.

The comparison gives a failed-bit mask, and the block keeps that mask. A later start with the retry flag raised pulses only the bits in that mask. The outcome of each run is graded by the number of failed bits:
- no failures is clean;
- one failure is correctable;
- two or more failures is uncorrectable.

An all-zero word is never sent to the array. It only raises a zero-skip flag.

A controller drives the start strobe and watches the ready output. The status flags are valid whenever ready is high.

Top module: `otp_word_programmer`

## Requirements
- R1: After reset, prog_ready is 1 and zero_skip, err_cor, err_unc, arr_prog_en and arr_rd_en are 0.
- R2: A start sampled while prog_ready is 1 with nonzero wdata (and retry allowed) drops prog_ready in the next cycle and clears zero_skip, err_cor and err_unc at the same time.
- R3: A first attempt (retry = 0) pulses exactly the bit positions where wdata is 1, one pulse per bit, in ascending bit index, with arr_row equal to the row_addr sampled at start.
- R4: Each pulse holds arr_prog_en high with a constant arr_bit for exactly pulse_width + 1 consecutive cycles.
- R5: After the last bit position, arr_rd_en is high for exactly one cycle. arr_rdata is sampled in that cycle, and a bit fails when it is 1 in wdata and 0 in arr_rdata. prog_ready returns to 1 in the next cycle.
- R6: err_cor is 1 after a run in which exactly one bit failed, and 0 otherwise.
- R7: err_unc is 1 after a run in which two or more bits failed, and 0 otherwise.
- R8: A start with retry = 1 pulses only the bits that failed in the previous run, and then verifies the full wdata.
- R9: A start with retry = 1 before any run has been accepted since reset is ignored: no pulse, no readback, prog_ready stays 1 and the flags keep their values.
- R10: A start with wdata all zero produces no pulse and no readback. prog_ready stays 1, zero_skip becomes 1 one cycle later, and the failed-bit mask is emptied.
- R11: A start asserted while prog_ready is 0 has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to program a word |
| retry | input | 1 | Marks the request as a retry of the previous run |
| row_addr | input | 13 | Physical row to program |
| wdata | input | 64 | Word to program |
| pulse_width | input | 8 | Pulse length minus one, in clock cycles |
| arr_prog_en | output | 1 | Programming pulse active on the selected bit |
| arr_row | output | 13 | Row under programming or readback |
| arr_bit | output | 6 | Bit being pulsed |
| arr_rd_en | output | 1 | Readback strobe |
| arr_rdata | input | 64 | Row contents, valid while arr_rd_en is high |
| prog_ready | output | 1 | 1 when idle, 0 while a run is in progress |
| zero_skip | output | 1 | Last accepted word was all zero |
| err_cor | output | 1 | Last run had exactly one failed bit |
| err_unc | output | 1 | Last run had two or more failed bits |

## Verification
The bench models the array with a per-test set of stuck bits, so it can create runs with exactly zero, one and many failures. A design that graded by the wrong count, or that let the two error flags overlap, would then report the wrong flag.

A retry following a partly failed run must pulse only the failed bits. A design that reused the full word would pulse bits that already read as 1, which the pulse monitor counts as unexpected.

The bench also issues a retry straight after reset, an all-zero word, a 256-cycle pulse and a start during a busy run. Getting these wrong would show up as, respectively:
- a spurious run;
- a pulse on an empty word;
- a pulse of the wrong length;
- a restarted sequence.

// File: rtl/otp_word_programmer.sv
module otp_word_programmer #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 13,
  parameter int PW_W   = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              retry,
  input  logic [ADDR_W-1:0] row_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PW_W-1:0]   pulse_width,
  output logic              arr_prog_en,
  output logic [ADDR_W-1:0] arr_row,
  output logic [IDX_W-1:0]  arr_bit,
  output logic              arr_rd_en,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              prog_ready,
  output logic              zero_skip,
  output logic              err_cor,
  output logic              err_unc
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
  localparam int CNT_W = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_PULSE, S_READ} state_t;

  state_t            state;
  logic [DATA_W-1:0] data_q, pend_q, fail_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PW_W-1:0]   pw_q, cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              tried_q;
  logic [DATA_W-1:0] fail_now;
  logic [CNT_W-1:0]  nfail;
  logic              accept;

  assign accept   = (state == S_IDLE) && start && (!retry || tried_q);
  assign fail_now = data_q & ~arr_rdata;

  always_comb begin
    nfail = '0;
    for (int i = 0; i < DATA_W; i++) nfail = nfail + CNT_W'(fail_now[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      data_q    <= '0;
      pend_q    <= '0;
      fail_q    <= '0;
      addr_q    <= '0;
      pw_q      <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      tried_q   <= 1'b0;
      zero_skip <= 1'b0;
      err_cor   <= 1'b0;
      err_unc   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          zero_skip <= 1'b0;
          err_cor   <= 1'b0;
          err_unc   <= 1'b0;
          tried_q   <= 1'b1;
          data_q    <= wdata;
          addr_q    <= row_addr;
          pw_q      <= pulse_width;
          idx_q     <= '0;
          if (wdata == '0) begin
            zero_skip <= 1'b1;
            fail_q    <= '0;
          end else begin
            pend_q <= retry ? fail_q : wdata;
            state  <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (pend_q[idx_q]) begin
            cnt_q <= '0;
            state <= S_PULSE;
          end else if (idx_q == LAST_IDX) begin
            state <= S_READ;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        S_PULSE: begin
          if (cnt_q == pw_q) begin
            if (idx_q == LAST_IDX) state <= S_READ;
            else begin
              idx_q <= idx_q + 1'b1;
              state <= S_SCAN;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_READ: begin
          fail_q  <= fail_now;
          err_cor <= (nfail == CNT_W'(1));
          err_unc <= (nfail > CNT_W'(1));
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign arr_prog_en = (state == S_PULSE);
  assign arr_rd_en   = (state == S_READ);
  assign arr_row     = addr_q;
  assign arr_bit     = idx_q;
  assign prog_ready  = (state == S_IDLE);

  // R4
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog_en && $past(arr_prog_en)) |-> $stable(arr_bit));

  // R6
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_cor && err_unc));

  // R10
  zero_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_skip |-> (!err_cor && !err_unc && prog_ready));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog_en || arr_rd_en) |-> !prog_ready);

  // R5
  read_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_rd_en |=> (prog_ready && !arr_rd_en));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_ready && start && !retry && wdata != '0) |=> (!prog_ready && !err_cor && !err_unc && !zero_skip));

endmodule

// File: tb/tb_otp_word_programmer.sv
module tb_otp_word_programmer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, retry = 1'b0;
  logic [12:0] row_addr = '0;
  logic [63:0] wdata = '0;
  logic [7:0]  pulse_width = '0;
  logic        arr_prog_en, arr_rd_en, prog_ready, zero_skip, err_cor, err_unc;
  logic [12:0] arr_row;
  logic [5:0]  arr_bit;
  logic [63:0] arr_rdata;

  logic [63:0] cells = '0, stuck = '0, exp_mask = '0, prev_fail = '0;
  logic [12:0] exp_row = '0;
  int          pw_cur = 0, last_bit = -1, pulses_seen = 0, reads_seen = 0;
  logic        in_run = 1'b0;
  int          cur_bit = 0, run_len = 0;
  int          checks = 0, fails = 0;
  int          cycles = 0;

  always #2.5 clk = ~clk;

  assign arr_rdata = arr_rd_en ? cells : 64'd0;

  otp_word_programmer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .retry(retry), .row_addr(row_addr),
    .wdata(wdata), .pulse_width(pulse_width), .arr_prog_en(arr_prog_en),
    .arr_row(arr_row), .arr_bit(arr_bit), .arr_rd_en(arr_rd_en), .arr_rdata(arr_rdata),
    .prog_ready(prog_ready), .zero_skip(zero_skip), .err_cor(err_cor), .err_unc(err_unc));

  function automatic int pc(input logic [63:0] v);
    int n = 0;
    for (int i = 0; i < 64; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    check(run_len == pw_cur + 1, "R4 pulse length", run_len, pw_cur + 1);
    check(exp_mask[cur_bit] && cur_bit > last_bit, "R3/R8 pulsed bit", cur_bit, last_bit);
    check(arr_row == exp_row, "R3 row", arr_row, exp_row);
    pulses_seen++;
    last_bit = cur_bit;
    if (!stuck[cur_bit]) cells[cur_bit] = 1'b1;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(0, "watchdog", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (rst_n) begin
      if (arr_rd_en) reads_seen++;
      if (arr_prog_en) begin
        if (in_run && int'(arr_bit) == cur_bit) run_len++;
        else begin
          if (in_run) finish_run();
          in_run = 1'b1; cur_bit = int'(arr_bit); run_len = 1;
        end
      end else if (in_run) begin
        finish_run();
        in_run = 1'b0;
      end
    end
  end

  task automatic run_op(input logic [63:0] d, input bit rt, input logic [12:0] a,
                        input logic [7:0] pw, input logic [63:0] stk, input bit busy_poke);
    logic [63:0] fin;
    int nf, w;
    @(negedge clk);
    if (!rt) cells = '0;
    stuck = stk;
    exp_mask = rt ? prev_fail : d;
    pulses_seen = 0; reads_seen = 0; last_bit = -1; pw_cur = pw; exp_row = a;
    start = 1'b1; retry = rt; row_addr = a; wdata = d; pulse_width = pw;
    @(negedge clk);
    start = 1'b0; retry = 1'b0;
    if (d == 64'd0) begin
      check(prog_ready, "R10 ready stays", prog_ready, 1);
      check(zero_skip && !err_cor && !err_unc, "R10 zero flag", {zero_skip, err_cor, err_unc}, 3'b100);
      @(negedge clk);
      check(pulses_seen == 0 && reads_seen == 0, "R10 no array access", pulses_seen + reads_seen, 0);
      prev_fail = '0;
      return;
    end
    check(!prog_ready, "R2 ready low", prog_ready, 0);
    check(!zero_skip && !err_cor && !err_unc, "R2 flags cleared", {zero_skip, err_cor, err_unc}, 0);
    if (busy_poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; wdata = ~d; row_addr = ~a; pulse_width = pw + 8'd3;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (!prog_ready && w < 40000) begin @(negedge clk); w++; end
    check(w < 40000, "R5 completes", w, 0);
    fin = d & ~cells;
    nf = pc(fin);
    check(pulses_seen == pc(exp_mask), rt ? "R8 pulse count" : "R3 pulse count", pulses_seen, pc(exp_mask));
    check(reads_seen == 1, "R5 single readback", reads_seen, 1);
    check(err_cor == (nf == 1), "R6 correctable flag", err_cor, nf == 1);
    check(err_unc == (nf > 1), "R7 uncorrectable flag", err_unc, nf > 1);
    check(!zero_skip, "R10 no zero flag", zero_skip, 0);
    if (busy_poke) begin
      @(negedge clk);
      check(prog_ready && pulses_seen == pc(exp_mask), "R11 busy start ignored", prog_ready, 1);
    end
    prev_fail = fin;
  endtask

  initial begin
    logic [63:0] d, s;
    void'($urandom(32'h5eed_0042));
    #1;
    check(prog_ready && !zero_skip && !err_cor && !err_unc && !arr_prog_en && !arr_rd_en,
          "R1 reset state", {prog_ready, zero_skip, err_cor, err_unc}, 4'b1000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(prog_ready && !zero_skip && !err_cor && !err_unc, "R1 after release", prog_ready, 1);

    // R9: retry before any attempt
    pulses_seen = 0; reads_seen = 0;
    start = 1'b1; retry = 1'b1; wdata = 64'hFF; pulse_width = 8'd1;
    @(negedge clk);
    start = 1'b0; retry = 1'b0;
    repeat (4) @(negedge clk);
    check(prog_ready && pulses_seen == 0 && reads_seen == 0 && !err_cor && !err_unc && !zero_skip,
          "R9 early retry ignored", pulses_seen + reads_seen, 0);

    // directed corners
    run_op(64'd0, 0, 13'h10, 8'd2, '0, 0);
    run_op(64'h8000_0000_0000_0001, 0, 13'h1FFF, 8'd255, '0, 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 0, 13'h0, 8'd0, 64'h0000_0100_0000_0000, 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 1, 13'h0, 8'd0, '0, 0);
    run_op(64'h0F0F_0000_00F0_0003, 0, 13'h55, 8'd3, 64'h0003_0000_0010_0002, 1);
    run_op(64'h0F0F_0000_00F0_0003, 1, 13'h55, 8'd3, 64'h0001_0000_0000_0000, 0);
    run_op(64'h0F0F_0000_00F0_0003, 1, 13'h55, 8'd1, '0, 0);
    run_op(64'd0, 0, 13'h3, 8'd0, '0, 0);
    run_op(64'h1234, 1, 13'h3, 8'd0, '0, 0);

    // random
    for (int n = 0; n < 40; n++) begin
      d = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom % 8 == 0) d = '0;
      s = '0;
      for (int k = 0; k < int'($urandom % 4); k++) s[$urandom % 64] = 1'b1;
      run_op(d, 0, 13'($urandom), 8'($urandom % 6), s, ($urandom % 5) == 0);
      if (prev_fail != '0) run_op(d, 1, exp_row, 8'($urandom % 6), '0, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule